// File: doc/BRIEF.md
# Width-Converting FIFO with Rewind

This block is a single-clock first-in first-out buffer whose write and read ports can each run at 40, 20 or 10 bits. Internally every entry is a 40-bit storage word. Narrow writes are gathered into one storage word before it is committed. Narrow reads take a committed storage word apart, one lane at a time. Five width pairings are supported: equal 40-bit ports, a wide writer feeding a 20- or 10-bit reader, and a 20- or 10-bit writer feeding a wide reader. The pairing is fixed at master reset, together with the flag mode and the default threshold selects.

A consumer can hold the `mark` input high to pin the current read position. A `retx` pulse then rewinds the read side to that position, so a block of data can be sent again. While the pin is held, the write side treats the pinned position as the oldest live word, so it never overwrites data that might be replayed.

A partial reset drops all stored data but keeps any threshold values loaded since the last master reset. Two flag modes are available. In standard mode an explicit read is needed to present each item on the output. In fall-through mode the head item is always visible, and ready flags replace the empty and full flags.

Top module: `bus_match_fifo`

## Requirements
- R1: Width codes are 0 = 40 bits, 1 = 20 bits, 2 = 10 bits and 3 = invalid. They are captured while `mrst` is high. The legal (write, read) pairs are (0,0), (0,1), (0,2), (1,0) and (2,0). Any other pair raises `cfgErr`, and while `cfgErr` is high all writes and reads are ignored.
- R2: A narrow writer supplies its lane on the low bits of `din`; the upper bits are ignored. The first narrow write lands in the least significant lane. No storage word becomes visible until its final lane is written.
- R3: A narrow reader receives the least significant lane of a storage word first, zero-extended on `dout`. The storage word is released only after its last lane is read.
- R4: In standard mode (`cfgFwft`=0), `dout` changes only on the clock edge of an accepted read and holds its value between reads. `flagEmpty` is high when no committed word remains. A read while empty has no effect.
- R5: In fall-through mode (`cfgFwft`=1), `dout` shows the head item without a read. `outReady` equals not-empty and `inReady` equals not-full. `flagEmpty` and `flagFull` read 0. In standard mode, `outReady` and `inReady` read 0.
- R6: `flagFull` is high when DEPTH storage words are held. Writes while full are dropped.
- R7: A write needs both `wcs` and `wen` high at the clock edge. A read needs both `rcs` and `ren` high at the clock edge.
- R8: On the first edge where `mark` is high, the word-level read position is recorded. While `mark` stays high, a `retx` pulse returns reading to lane 0 of the recorded word. Lowering `mark` releases the record.
- R9: While a mark is held, fullness is counted from the marked position rather than from the read position.
- R10: `almostEmpty` is high when the stored word count is at most the empty threshold. `almostFull` is high when the free word count is at most the full threshold.
- R11: At master reset each threshold takes a default from its 2-bit select: 0→7, 1→31, 2→63, 3→127. `ldAe` or `ldAf` with `ldVal` overwrites the corresponding threshold.
- R12: `prst` empties the buffer and clears any mark, but keeps the thresholds. `mrst` also restores the default thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| cfgWrWidth | input | 2 | Write width code, captured during mrst |
| cfgRdWidth | input | 2 | Read width code, captured during mrst |
| cfgFwft | input | 1 | Fall-through mode select, captured during mrst |
| cfgAeSel | input | 2 | Default empty-threshold select |
| cfgAfSel | input | 2 | Default full-threshold select |
| ldAe | input | 1 | Load empty threshold from ldVal |
| ldAf | input | 1 | Load full threshold from ldVal |
| ldVal | input | OFFW | Threshold value to load |
| wcs | input | 1 | Write chip select |
| wen | input | 1 | Write enable |
| din | input | 40 | Write data, lane on low bits |
| rcs | input | 1 | Read chip select |
| ren | input | 1 | Read enable |
| dout | output | 40 | Read data |
| mark | input | 1 | Hold to pin the read position |
| retx | input | 1 | Rewind to the pinned position |
| flagEmpty | output | 1 | Empty, standard mode |
| flagFull | output | 1 | Full, standard mode |
| outReady | output | 1 | Output valid, fall-through mode |
| inReady | output | 1 | Space available, fall-through mode |
| almostEmpty | output | 1 | Stored words at or below threshold |
| almostFull | output | 1 | Free words at or below threshold |
| cfgErr | output | 1 | Illegal width pairing |

## Verification
The hardest case to reach is a buffer that reports full even though the reader has drained everything. This happens only when a held mark keeps old words alive. The stimulus pins the mark on an empty buffer, writes and reads ten words, and then writes until the total since the mark reaches DEPTH. It then checks that an extra write is dropped. After the mark is released, it drains the buffer through the scoreboard to show that the dropped word never appears. Partial-word states are reached by stopping a narrow write sequence one lane short and by checking the empty flag between lanes of a narrow read.

// File: rtl/fifo_bm_pkg.sv
package fifo_bm_pkg;

  localparam int WORD_W = 40;

  typedef struct packed {
    logic       wrTake;
    logic       wrLast;
    logic [1:0] wrLane;
    logic [1:0] wrMode;
    logic       rdTake;
    logic [1:0] rdLane;
    logic [1:0] rdMode;
    logic       fwft;
    logic       clrAll;
  } strobe_t;

  function automatic int laneWidth(logic [1:0] m);
    case (m)
      2'd1:    return 20;
      2'd2:    return 10;
      default: return WORD_W;
    endcase
  endfunction

  function automatic logic [1:0] lastLane(logic [1:0] m);
    case (m)
      2'd1:    return 2'd1;
      2'd2:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic legalPair(logic [1:0] w, logic [1:0] r);
    return (w == 2'd0 && r != 2'd3) || (r == 2'd0 && (w == 2'd1 || w == 2'd2));
  endfunction

  function automatic logic [7:0] defOffset(logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd7;
      2'd1:    return 8'd31;
      2'd2:    return 8'd63;
      default: return 8'd127;
    endcase
  endfunction

  // place a narrow lane of d into word at the given lane index
  function automatic logic [WORD_W-1:0] insertLane(logic [WORD_W-1:0] word,
      logic [WORD_W-1:0] d, logic [1:0] m, logic [1:0] lane);
    logic [WORD_W-1:0] r;
    int sw;
    int base;
    r    = word;
    sw   = laneWidth(m);
    base = int'(lane) * sw;
    for (int b = 0; b < WORD_W; b++)
      if (b >= base && b < base + sw) r[b] = d[6'(b - base)];
    return r;
  endfunction

  // pull one lane out of word, zero-extended
  function automatic logic [WORD_W-1:0] extractLane(logic [WORD_W-1:0] word,
      logic [1:0] m, logic [1:0] lane);
    logic [WORD_W-1:0] r;
    int sw;
    int base;
    r    = '0;
    sw   = laneWidth(m);
    base = int'(lane) * sw;
    for (int b = 0; b < WORD_W; b++)
      if (b < sw) r[b] = word[6'(base + b)];
    return r;
  endfunction

endpackage

// File: rtl/fifo_bm_ctrl.sv
module fifo_bm_ctrl
  import fifo_bm_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFFW  = 8
) (
  input  logic                     clk,
  input  logic                     mrst,
  input  logic                     prst,
  input  logic [1:0]               cfgWrWidth,
  input  logic [1:0]               cfgRdWidth,
  input  logic                     cfgFwft,
  input  logic [1:0]               cfgAeSel,
  input  logic [1:0]               cfgAfSel,
  input  logic                     ldAe,
  input  logic                     ldAf,
  input  logic [OFFW-1:0]          ldVal,
  input  logic                     wcs,
  input  logic                     wen,
  input  logic                     rcs,
  input  logic                     ren,
  input  logic                     mark,
  input  logic                     retx,
  output strobe_t                  st,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic                     flagEmpty,
  output logic                     flagFull,
  output logic                     outReady,
  output logic                     inReady,
  output logic                     almostEmpty,
  output logic                     almostFull,
  output logic                     cfgErr
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTHP = PW'(DEPTH);

  logic [1:0]      wrModeQ, rdModeQ;
  logic            fwftQ;
  logic [OFFW-1:0] aeOff, afOff;
  logic [PW-1:0]   wrPtr, rdPtr, markPtr;
  logic [1:0]      wrLane, rdLane;
  logic            markActive;

  logic [PW-1:0] usedRd, usedWr, freeWr;
  logic isEmpty, isFull, wrLast, rdLast, wrOk, rdOk, doRetx;

  always_comb begin
    usedRd  = wrPtr - rdPtr;
    usedWr  = wrPtr - (markActive ? markPtr : rdPtr);
    freeWr  = DEPTHP - usedWr;
    isEmpty = (usedRd == '0);
    isFull  = (usedWr == DEPTHP);
    cfgErr  = !legalPair(wrModeQ, rdModeQ);
    wrLast  = (wrLane == lastLane(wrModeQ));
    rdLast  = (rdLane == lastLane(rdModeQ));
    wrOk    = wcs && wen && !isFull && !cfgErr && !prst;
    doRetx  = retx && markActive && !cfgErr && !prst;
    rdOk    = rcs && ren && !isEmpty && !cfgErr && !prst && !doRetx;
  end

  // configuration and thresholds
  always_ff @(posedge clk) begin
    if (mrst) begin
      wrModeQ <= cfgWrWidth;
      rdModeQ <= cfgRdWidth;
      fwftQ   <= cfgFwft;
      aeOff   <= OFFW'(defOffset(cfgAeSel));
      afOff   <= OFFW'(defOffset(cfgAfSel));
    end else if (!prst) begin
      if (ldAe) aeOff <= ldVal;
      if (ldAf) afOff <= ldVal;
    end
  end

  // pointers, lanes and mark
  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      markPtr    <= '0;
      wrLane     <= '0;
      rdLane     <= '0;
      markActive <= 1'b0;
    end else begin
      if (wrOk) begin
        if (wrLast) begin
          wrPtr  <= wrPtr + PW'(1);
          wrLane <= '0;
        end else begin
          wrLane <= wrLane + 2'd1;
        end
      end
      if (doRetx) begin
        rdPtr  <= markPtr;
        rdLane <= '0;
      end else if (rdOk) begin
        if (rdLast) begin
          rdPtr  <= rdPtr + PW'(1);
          rdLane <= '0;
        end else begin
          rdLane <= rdLane + 2'd1;
        end
      end
      if (!mark) begin
        markActive <= 1'b0;
      end else if (!markActive) begin
        markActive <= 1'b1;
        markPtr    <= rdPtr;
      end
    end
  end

  always_comb begin
    st.wrTake = wrOk;
    st.wrLast = wrLast;
    st.wrLane = wrLane;
    st.wrMode = wrModeQ;
    st.rdTake = rdOk;
    st.rdLane = rdLane;
    st.rdMode = rdModeQ;
    st.fwft   = fwftQ;
    st.clrAll = mrst || prst;
    wrAddr    = wrPtr[AW-1:0];
    rdAddr    = rdPtr[AW-1:0];
    flagEmpty   = !fwftQ && isEmpty;
    flagFull    = !fwftQ && isFull;
    outReady    = fwftQ && !isEmpty;
    inReady     = fwftQ && !isFull;
    almostEmpty = (32'(usedRd) <= 32'(aeOff));
    almostFull  = (32'(freeWr) <= 32'(afOff));
  end

  // R1: an illegal pairing freezes both pointers
  p_cfg_block_r1: assert property (@(posedge clk) disable iff (mrst)
    cfgErr |=> $stable(wrPtr) && $stable(rdPtr));

  // R4: no read progress while empty
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (mrst)
    isEmpty && !prst && !doRetx |=> rdPtr == $past(rdPtr));

  // R6: the write pointer holds while full
  p_full_hold_r6: assert property (@(posedge clk) disable iff (mrst)
    isFull && !prst |=> wrPtr == $past(wrPtr));

  // R8: a rewind lands on the recorded word
  p_retx_rewind_r8: assert property (@(posedge clk) disable iff (mrst)
    doRetx |=> rdPtr == $past(markPtr) && rdLane == 2'd0);

  // R9: the live span never exceeds the storage
  p_no_overrun_r9: assert property (@(posedge clk) disable iff (mrst)
    usedWr <= DEPTHP);

  // R12: a partial reset keeps both thresholds
  p_prst_keep_r12: assert property (@(posedge clk) disable iff (mrst)
    prst |=> aeOff == $past(aeOff) && afOff == $past(afOff));

endmodule

// File: rtl/fifo_bm_data.sv
module fifo_bm_data
  import fifo_bm_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  strobe_t                  st,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [WORD_W-1:0]        din,
  output logic [WORD_W-1:0]        dout
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] packQ, merged, headLane, doutQ;

  always_comb begin
    merged   = insertLane(packQ, din, st.wrMode, st.wrLane);
    headLane = extractLane(mem[rdAddr], st.rdMode, st.rdLane);
    dout     = st.fwft ? headLane : doutQ;
  end

  // packing register: partial storage word under construction
  always_ff @(posedge clk) begin
    if (st.clrAll)
      packQ <= '0;
    else if (st.wrTake)
      packQ <= st.wrLast ? '0 : merged;
  end

  always_ff @(posedge clk) begin
    if (st.wrTake && st.wrLast) mem[wrAddr] <= merged;
  end

  // standard-mode output register
  always_ff @(posedge clk) begin
    if (st.clrAll)
      doutQ <= '0;
    else if (st.rdTake && !st.fwft)
      doutQ <= headLane;
  end

endmodule

// File: rtl/bus_match_fifo.sv
module bus_match_fifo
  import fifo_bm_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFFW  = 8
) (
  input  logic            clk,
  input  logic            mrst,
  input  logic            prst,
  input  logic [1:0]      cfgWrWidth,
  input  logic [1:0]      cfgRdWidth,
  input  logic            cfgFwft,
  input  logic [1:0]      cfgAeSel,
  input  logic [1:0]      cfgAfSel,
  input  logic            ldAe,
  input  logic            ldAf,
  input  logic [OFFW-1:0] ldVal,
  input  logic            wcs,
  input  logic            wen,
  input  logic [39:0]     din,
  input  logic            rcs,
  input  logic            ren,
  output logic [39:0]     dout,
  input  logic            mark,
  input  logic            retx,
  output logic            flagEmpty,
  output logic            flagFull,
  output logic            outReady,
  output logic            inReady,
  output logic            almostEmpty,
  output logic            almostFull,
  output logic            cfgErr
);

  localparam int AW = $clog2(DEPTH);

  strobe_t       st;
  logic [AW-1:0] wrAddr, rdAddr;

  fifo_bm_ctrl #(.DEPTH(DEPTH), .OFFW(OFFW)) i_ctrl (
    .clk(clk), .mrst(mrst), .prst(prst),
    .cfgWrWidth(cfgWrWidth), .cfgRdWidth(cfgRdWidth), .cfgFwft(cfgFwft),
    .cfgAeSel(cfgAeSel), .cfgAfSel(cfgAfSel),
    .ldAe(ldAe), .ldAf(ldAf), .ldVal(ldVal),
    .wcs(wcs), .wen(wen), .rcs(rcs), .ren(ren),
    .mark(mark), .retx(retx),
    .st(st), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .flagEmpty(flagEmpty), .flagFull(flagFull),
    .outReady(outReady), .inReady(inReady),
    .almostEmpty(almostEmpty), .almostFull(almostFull),
    .cfgErr(cfgErr)
  );

  fifo_bm_data #(.DEPTH(DEPTH)) i_data (
    .clk(clk), .st(st), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .din(din), .dout(dout)
  );

endmodule

// File: tb/test_bus_match_fifo.sv
module test_bus_match_fifo;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;

  logic        clk = 1'b0;
  logic        mrst = 1'b1, prst = 1'b0;
  logic [1:0]  cfgWrWidth = '0, cfgRdWidth = '0, cfgAeSel = '0, cfgAfSel = '0;
  logic        cfgFwft = 1'b0;
  logic        ldAe = 1'b0, ldAf = 1'b0;
  logic [7:0]  ldVal = '0;
  logic        wcs = 1'b1, wen = 1'b0, rcs = 1'b1, ren = 1'b0;
  logic [39:0] din = '0;
  logic [39:0] dout;
  logic        mark = 1'b0, retx = 1'b0;
  logic        flagEmpty, flagFull, outReady, inReady, almostEmpty, almostFull, cfgErr;

  int nChk = 0;
  int nFail = 0;
  logic [39:0] expQ[$];
  bit chkRd = 1'b0;
  string curReq = "R4";

  always #(PERIOD/2) clk = ~clk;

  bus_match_fifo #(.DEPTH(DEPTH), .OFFW(8)) i_bus_match_fifo (
    .clk(clk), .mrst(mrst), .prst(prst),
    .cfgWrWidth(cfgWrWidth), .cfgRdWidth(cfgRdWidth), .cfgFwft(cfgFwft),
    .cfgAeSel(cfgAeSel), .cfgAfSel(cfgAfSel),
    .ldAe(ldAe), .ldAf(ldAf), .ldVal(ldVal),
    .wcs(wcs), .wen(wen), .din(din), .rcs(rcs), .ren(ren), .dout(dout),
    .mark(mark), .retx(retx),
    .flagEmpty(flagEmpty), .flagFull(flagFull), .outReady(outReady), .inReady(inReady),
    .almostEmpty(almostEmpty), .almostFull(almostFull), .cfgErr(cfgErr)
  );

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard after every expected read
  bit took;
  logic [39:0] expV;
  always @(posedge clk) begin
    took = chkRd;
    #1;
    if (took) begin
      if (expQ.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL %s: got %h expected no read", curReq, dout);
      end else begin
        expV = expQ.pop_front();
        chk(curReq, dout, expV);
      end
    end
  end

  task automatic doReset(logic [1:0] w, logic [1:0] r, logic f, logic [1:0] ae, logic [1:0] af);
    mrst = 1'b1; cfgWrWidth = w; cfgRdWidth = r; cfgFwft = f; cfgAeSel = ae; cfgAfSel = af;
    repeat (2) @(negedge clk);
    mrst = 1'b0;
  endtask

  task automatic wr(logic [39:0] d);
    wen = 1'b1; din = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rdExp(logic [39:0] d);
    ren = 1'b1; chkRd = 1'b1; expQ.push_back(d);
    @(negedge clk);
    ren = 1'b0; chkRd = 1'b0;
  endtask

  task automatic rdNone();
    ren = 1'b1;
    @(negedge clk);
    ren = 1'b0;
  endtask

  initial begin
    #(PERIOD * 50000);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  logic [39:0] w;

  initial begin
    @(negedge clk);
    doReset(0, 0, 0, 0, 0);
    // R12 / R4: state after master reset
    chk("R12 reset empty", 40'(flagEmpty), 40'd1);
    chk("R6 reset full", 40'(flagFull), 40'd0);
    chk("R10 reset aEmpty", 40'(almostEmpty), 40'd1);
    chk("R1 reset cfgErr", 40'(cfgErr), 40'd0);
    chk("R4 reset dout", dout, 40'd0);

    // R4: basic order and read-while-empty
    curReq = "R4";
    wr(40'h11_1111_1111); wr(40'h22_2222_2222); wr(40'h33_3333_3333);
    rdExp(40'h11_1111_1111); rdExp(40'h22_2222_2222); rdExp(40'h33_3333_3333);
    rdNone();
    chk("R4 empty read holds dout", dout, 40'h33_3333_3333);
    chk("R4 empty flag", 40'(flagEmpty), 40'd1);

    // R7: chip selects
    wcs = 1'b0; wr(40'hBAD); wcs = 1'b1;
    chk("R7 wcs low ignored", 40'(flagEmpty), 40'd1);
    wr(40'h44);
    rcs = 1'b0; rdNone(); rcs = 1'b1;
    chk("R7 rcs low ignored", 40'(flagEmpty), 40'd0);
    chk("R7 rcs low dout held", dout, 40'h33_3333_3333);
    curReq = "R7"; rdExp(40'h44);

    // R6 / R10: fill, thresholds, overflow
    curReq = "R6";
    for (int i = 0; i < DEPTH; i++) begin
      wr(40'(i + 100));
      if (i == 55) chk("R10 aFull off at 56", 40'(almostFull), 40'd0);
      if (i == 56) chk("R10 aFull on at 57", 40'(almostFull), 40'd1);
    end
    chk("R6 full", 40'(flagFull), 40'd1);
    wr(40'hDEAD);
    for (int i = 0; i < DEPTH; i++) begin
      rdExp(40'(i + 100));
      if (i == 55) chk("R10 aEmpty off at 8", 40'(almostEmpty), 40'd0);
      if (i == 56) chk("R10 aEmpty on at 7", 40'(almostEmpty), 40'd1);
    end
    chk("R6 drained", 40'(flagEmpty), 40'd1);

    // R2: 10-bit writer packs low lane first
    doReset(2, 0, 0, 0, 0);
    curReq = "R2";
    wr({30'h2AAAAAAA, 10'h3A5}); wr({30'h15555555, 10'h15C}); wr({30'h3FFFFFFF, 10'h2F0});
    chk("R2 partial word hidden", 40'(flagEmpty), 40'd1);
    wr({30'h0, 10'h0C3});
    rdExp({10'h0C3, 10'h2F0, 10'h15C, 10'h3A5});
    doReset(1, 0, 0, 0, 0);
    wr({20'hFFFFF, 20'h12345}); wr({20'h0F0F0, 20'hABCDE});
    rdExp({20'hABCDE, 20'h12345});

    // R3: unpack
    doReset(0, 2, 0, 0, 0);
    curReq = "R3";
    w = 40'h9C_3A5B_71E4;
    wr(w);
    rdExp({30'h0, w[9:0]}); rdExp({30'h0, w[19:10]});
    chk("R3 word kept mid-unpack", 40'(flagEmpty), 40'd0);
    rdExp({30'h0, w[29:20]}); rdExp({30'h0, w[39:30]});
    chk("R3 word released", 40'(flagEmpty), 40'd1);
    doReset(0, 1, 0, 0, 0);
    wr(w);
    rdExp({20'h0, w[19:0]}); rdExp({20'h0, w[39:20]});

    // R1: illegal pairings
    doReset(1, 1, 0, 0, 0);
    chk("R1 pair 20/20 illegal", 40'(cfgErr), 40'd1);
    wr(40'h5);
    chk("R1 write blocked", 40'(flagEmpty), 40'd1);
    doReset(3, 0, 0, 0, 0);
    chk("R1 code 3 illegal", 40'(cfgErr), 40'd1);
    doReset(2, 0, 0, 0, 0);
    chk("R1 pair 10/40 legal", 40'(cfgErr), 40'd0);

    // R5: fall-through
    doReset(0, 0, 1, 0, 0);
    chk("R5 outReady empty", 40'(outReady), 40'd0);
    chk("R5 inReady", 40'(inReady), 40'd1);
    chk("R5 flagEmpty unused", 40'(flagEmpty), 40'd0);
    wr(40'hA1);
    chk("R5 outReady", 40'(outReady), 40'd1);
    chk("R5 head shown without read", dout, 40'hA1);
    wr(40'hB2);
    chk("R5 head holds", dout, 40'hA1);
    rdNone();
    chk("R5 next head", dout, 40'hB2);
    rdNone();
    chk("R5 drained", 40'(outReady), 40'd0);

    // R8: mark and rewind
    doReset(0, 0, 0, 0, 0);
    curReq = "R8";
    for (int i = 0; i < 5; i++) wr(40'(200 + i));
    rdExp(40'd200);
    mark = 1'b1; @(negedge clk);
    rdExp(40'd201); rdExp(40'd202);
    retx = 1'b1; @(negedge clk); retx = 1'b0;
    rdExp(40'd201); rdExp(40'd202); rdExp(40'd203); rdExp(40'd204);
    chk("R8 empty after replay", 40'(flagEmpty), 40'd1);
    mark = 1'b0; @(negedge clk);

    // R9: full counted from mark
    doReset(0, 0, 0, 0, 0);
    curReq = "R9";
    mark = 1'b1; @(negedge clk);
    for (int i = 0; i < 10; i++) wr(40'(300 + i));
    for (int i = 0; i < 10; i++) rdExp(40'(300 + i));
    for (int i = 0; i < DEPTH - 10; i++) wr(40'(400 + i));
    chk("R9 full from mark", 40'(flagFull), 40'd1);
    wr(40'hBEEF);
    mark = 1'b0; @(negedge clk);
    chk("R9 released", 40'(flagFull), 40'd0);
    for (int i = 0; i < DEPTH - 10; i++) rdExp(40'(400 + i));
    chk("R9 extra write dropped", 40'(flagEmpty), 40'd1);

    // R11 / R12: thresholds
    doReset(0, 0, 0, 0, 0);
    ldAe = 1'b1; ldVal = 8'd3; @(negedge clk); ldAe = 1'b0;
    for (int i = 0; i < 4; i++) wr(40'(i));
    chk("R11 loaded threshold", 40'(almostEmpty), 40'd0);
    prst = 1'b1; @(negedge clk); prst = 1'b0;
    chk("R12 partial reset empties", 40'(flagEmpty), 40'd1);
    for (int i = 0; i < 4; i++) wr(40'(i));
    chk("R12 threshold kept", 40'(almostEmpty), 40'd0);
    doReset(0, 0, 0, 1, 3);
    chk("R11 full default 127", 40'(almostFull), 40'd1);
    for (int i = 0; i < 31; i++) wr(40'(i));
    chk("R11 empty default 31 at 31", 40'(almostEmpty), 40'd1);
    wr(40'd31);
    chk("R11 empty default 31 at 32", 40'(almostEmpty), 40'd0);
    doReset(0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) wr(40'(i));
    chk("R12 master reset restores 7", 40'(almostEmpty), 40'd1);

    chk("R4 scoreboard drained", 40'(expQ.size()), 40'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule